// File: doc/BRIEF.md
# Lockable APB Watchdog Timer

This peripheral sits on an APB slave port and watches for software that has stopped running. A 32-bit counter counts down from a programmable start value once counting is switched on. When it passes through zero it raises an interrupt and starts again from the start value. If that interrupt has not been cleared by the next time the counter passes through zero, and reset escalation is enabled, the block raises a sticky reset request. Software keeps the system alive by clearing the interrupt, which also restarts the count.

All configuration registers are write-protected. Writing a magic key to the lock word opens them. Writing any other value to the lock word closes them again. The block leaves reset in the locked state. Software can read the interrupt in two forms: raw, and gated by the enable bit. A test mode takes both outputs away from the counter logic and drives them straight from a software-written register.

Top module: `wdt_apb_top`

## Requirements
- R1: After reset the lock word (0xC00) reads 1, the start value (0x000) and the live count (0x004) read 0xFFFFFFFF, control (0x008) reads 0, and both outputs are low.
- R2: Writing 0x1ACCE551 to 0xC00 makes it read 0 (unlocked). Writing any other value, 0x2BDDF662 included, makes it read 1 (locked).
- R3: While locked, writes to every address except 0xC00 leave the registers and the outputs unchanged.
- R4: A write to 0x000 sets both the start value and the live count to the written value on the commit edge.
- R5: With control bit 0 set, the count falls by exactly 1 each clock. With bit 0 clear, the count holds.
- R6: While running, the clock that finds the count at zero sets the raw interrupt and reloads the start value. A start value of L therefore gives a period of L+1 clocks.
- R7: A zero crossing that finds the raw interrupt still set, with control bit 1 set, asserts the reset output. The reset output then stays high until the block is reset. With bit 1 clear, the reset output never asserts.
- R8: Writing bit 0 = 1 to 0x00C clears the raw interrupt and reloads the count from the start value.
- R9: Address 0x010 returns the raw interrupt in bit 0. Address 0x014 returns the raw interrupt ANDed with control bit 0. Outside test mode the interrupt output equals the value at 0x014.
- R10: With bit 0 of 0xF00 set, the interrupt output follows bit 0 and the reset output follows bit 1 of the value last written to 0xF04.
- R11: Reads of 0x00C, 0xF04 and unmapped addresses return 0. pready is always 1 and pslverr is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and counter clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write transfer |
| paddr | input | 12 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Never signals an error |
| wdt_irq | output | 1 | Interrupt output |
| wdt_rst | output | 1 | Reset request output |

## Verification
The count is exercised in four patterns, and each one separates a different kind of fault.
- Period measurement: a start value of 100 with the reset stage disabled gives a period measured in clocks. A wrong reload point or a wrong expiry test shows up as an off-by-one period.
- Back-to-back reads: reading the running count in consecutive transfers checks the decrement step.
- Short two-stage run: a start value of 5 with escalation enabled checks the spacing between the interrupt and the reset request.
- Escalation disabled: the same short run with escalation off shows that the reset stage depends on control bit 1.

Around these runs, the bench checks three further behaviours:
- Key and relock writes.
- Writes attempted while the block is locked.
- Test-mode output patterns, which separate the bus path from the counter path.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [11:0] OFS_LOAD  = 12'h000;
  localparam logic [11:0] OFS_COUNT = 12'h004;
  localparam logic [11:0] OFS_CTRL  = 12'h008;
  localparam logic [11:0] OFS_ICLR  = 12'h00C;
  localparam logic [11:0] OFS_RAW   = 12'h010;
  localparam logic [11:0] OFS_MSK   = 12'h014;
  localparam logic [11:0] OFS_LOCK  = 12'hC00;
  localparam logic [11:0] OFS_TCTL  = 12'hF00;
  localparam logic [11:0] OFS_TSET  = 12'hF04;

  localparam logic [31:0] OPEN_KEY  = 32'h1ACCE551;

  typedef struct packed {
    logic rst_en;
    logic run_en;
  } ctrl_t;

  typedef struct packed {
    logic rst_drv;
    logic irq_drv;
  } tset_t;
endpackage

// File: rtl/wdt_regfile.sv
module wdt_regfile
  import wdt_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 32
) (
  input  logic          pclk,
  input  logic          presetn,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [11:0]   paddr,
  input  logic [DW-1:0] pwdata,
  input  logic [CW-1:0] cnt,
  input  logic          raw_irq,
  output logic [DW-1:0] prdata,
  output logic          locked,
  output logic [CW-1:0] load_q,
  output ctrl_t         ctrl_q,
  output logic          load_wr,
  output logic          clr_pulse,
  output logic          test_mode,
  output tset_t         tset_q
);
  // Zero-extend a counter-width value onto the data bus.
  function automatic logic [DW-1:0] zext(input logic [CW-1:0] v);
    logic [DW-1:0] r;
    r = '0;
    r[CW-1:0] = v;
    return r;
  endfunction

  logic wr_acc;
  logic cfg_wr;
  logic lock_wr;

  assign wr_acc    = psel & penable & pwrite;
  assign cfg_wr    = wr_acc & ~locked;
  assign lock_wr   = wr_acc & (paddr == OFS_LOCK);
  assign load_wr   = cfg_wr & (paddr == OFS_LOAD);
  assign clr_pulse = cfg_wr & (paddr == OFS_ICLR) & pwdata[0];

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      locked    <= 1'b1;
      load_q    <= '1;
      ctrl_q    <= '0;
      test_mode <= 1'b0;
      tset_q    <= '0;
    end else begin
      if (lock_wr)
        locked <= (pwdata != DW'(OPEN_KEY));
      if (load_wr)
        load_q <= pwdata[CW-1:0];
      if (cfg_wr && paddr == OFS_CTRL)
        ctrl_q <= ctrl_t'(pwdata[1:0]);
      if (cfg_wr && paddr == OFS_TCTL)
        test_mode <= pwdata[0];
      if (cfg_wr && paddr == OFS_TSET)
        tset_q <= tset_t'(pwdata[1:0]);
    end
  end

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      case (paddr)
        OFS_LOAD:  prdata = zext(load_q);
        OFS_COUNT: prdata = zext(cnt);
        OFS_CTRL:  prdata[1:0] = ctrl_q;
        OFS_RAW:   prdata[0] = raw_irq;
        OFS_MSK:   prdata[0] = raw_irq & ctrl_q.run_en;
        OFS_LOCK:  prdata[0] = locked;
        OFS_TCTL:  prdata[0] = test_mode;
        default:   prdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rstn,
  input  logic          run_en,
  input  logic          rst_en,
  input  logic          load_wr,
  input  logic [CW-1:0] load_new,
  input  logic [CW-1:0] load_q,
  input  logic          clr,
  output logic [CW-1:0] cnt,
  output logic          expire,
  output logic          raw_irq,
  output logic          rst_q
);
  function automatic logic [CW-1:0] step_down(input logic [CW-1:0] v);
    return v - {{(CW-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic at_zero(input logic [CW-1:0] v);
    return (v == '0);
  endfunction

  // Bus writes take priority over the count; expiry only on a quiet cycle.
  assign expire = run_en & at_zero(cnt) & ~load_wr & ~clr;

  always_ff @(posedge clk or negedge rstn) begin
    if (!rstn) begin
      cnt     <= '1;
      raw_irq <= 1'b0;
      rst_q   <= 1'b0;
    end else begin
      if (load_wr)
        cnt <= load_new;
      else if (clr)
        cnt <= load_q;
      else if (run_en)
        cnt <= expire ? load_q : step_down(cnt);

      if (clr)
        raw_irq <= 1'b0;
      else if (expire)
        raw_irq <= 1'b1;

      if (expire && raw_irq && rst_en)
        rst_q <= 1'b1;
    end
  end
endmodule

// File: rtl/wdt_outmux.sv
module wdt_outmux
  import wdt_pkg::*;
(
  input  logic  test_mode,
  input  tset_t tset_q,
  input  logic  raw_irq,
  input  logic  run_en,
  input  logic  rst_q,
  output logic  irq,
  output logic  rst
);
  always_comb begin
    if (test_mode) begin
      irq = tset_q.irq_drv;
      rst = tset_q.rst_drv;
    end else begin
      irq = raw_irq & run_en;
      rst = rst_q;
    end
  end
endmodule

// File: rtl/wdt_apb_top.sv
module wdt_apb_top
  import wdt_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 32
) (
  input  logic          pclk,
  input  logic          presetn,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [11:0]   paddr,
  input  logic [DW-1:0] pwdata,
  output logic [DW-1:0] prdata,
  output logic          pready,
  output logic          pslverr,
  output logic          wdt_irq,
  output logic          wdt_rst
);
  logic [CW-1:0] load_q;
  logic [CW-1:0] cnt;
  ctrl_t         ctrl_q;
  tset_t         tset_q;
  logic          locked;
  logic          load_wr;
  logic          clr_pulse;
  logic          test_mode;
  logic          expire;
  logic          raw_irq;
  logic          rst_q;
  logic          run_en;
  logic          rst_en;

  assign run_en  = ctrl_q.run_en;
  assign rst_en  = ctrl_q.rst_en;
  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  wdt_regfile #(.DW(DW), .CW(CW)) i_regs (
    .pclk      (pclk),
    .presetn   (presetn),
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .paddr     (paddr),
    .pwdata    (pwdata),
    .cnt       (cnt),
    .raw_irq   (raw_irq),
    .prdata    (prdata),
    .locked    (locked),
    .load_q    (load_q),
    .ctrl_q    (ctrl_q),
    .load_wr   (load_wr),
    .clr_pulse (clr_pulse),
    .test_mode (test_mode),
    .tset_q    (tset_q)
  );

  wdt_counter #(.CW(CW)) i_cnt (
    .clk      (pclk),
    .rstn     (presetn),
    .run_en   (run_en),
    .rst_en   (rst_en),
    .load_wr  (load_wr),
    .load_new (pwdata[CW-1:0]),
    .load_q   (load_q),
    .clr      (clr_pulse),
    .cnt      (cnt),
    .expire   (expire),
    .raw_irq  (raw_irq),
    .rst_q    (rst_q)
  );

  wdt_outmux i_mux (
    .test_mode (test_mode),
    .tset_q    (tset_q),
    .raw_irq   (raw_irq),
    .run_en    (run_en),
    .rst_q     (rst_q),
    .irq       (wdt_irq),
    .rst       (wdt_rst)
  );
endmodule

// File: rtl/wdt_apb_checker.sv
module wdt_apb_checker #(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rstn,
  input logic          psel,
  input logic          penable,
  input logic          pwrite,
  input logic [11:0]   paddr,
  input logic          locked,
  input logic [CW-1:0] load_q,
  input logic [CW-1:0] cnt,
  input logic          expire,
  input logic          raw_irq,
  input logic          rst_q,
  input logic          run_en,
  input logic          load_wr,
  input logic          clr_pulse,
  input logic          test_mode,
  input logic [1:0]    tset_q,
  input logic          irq,
  input logic          rst
);
  AST_LOCKED_LOAD_HOLD: assert property (@(posedge clk) disable iff (!rstn)
    (psel && penable && pwrite && locked && paddr == 12'h000) |=> $stable(load_q)); // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstn)
    (run_en && !expire && !load_wr && !clr_pulse) |=> (cnt == $past(cnt) - 1'b1)); // R5
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rstn)
    (!run_en && !load_wr && !clr_pulse) |=> $stable(cnt)); // R5
  AST_EXPIRE_RELOAD: assert property (@(posedge clk) disable iff (!rstn)
    expire |=> (cnt == $past(load_q))); // R6
  AST_EXPIRE_IRQ: assert property (@(posedge clk) disable iff (!rstn)
    expire |=> raw_irq); // R6
  AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rstn)
    rst_q |=> rst_q); // R7
  AST_CLR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rstn)
    clr_pulse |=> !raw_irq); // R8
  AST_MASKED_OUT: assert property (@(posedge clk) disable iff (!rstn)
    !test_mode |-> (irq == (raw_irq && run_en))); // R9
  AST_TEST_DRIVE: assert property (@(posedge clk) disable iff (!rstn)
    test_mode |-> (irq == tset_q[0] && rst == tset_q[1])); // R10
endmodule

bind wdt_apb_top wdt_apb_checker #(.CW(CW)) i_chk (
  .clk       (pclk),
  .rstn      (presetn),
  .psel      (psel),
  .penable   (penable),
  .pwrite    (pwrite),
  .paddr     (paddr),
  .locked    (locked),
  .load_q    (load_q),
  .cnt       (cnt),
  .expire    (expire),
  .raw_irq   (raw_irq),
  .rst_q     (rst_q),
  .run_en    (run_en),
  .load_wr   (load_wr),
  .clr_pulse (clr_pulse),
  .test_mode (test_mode),
  .tset_q    (tset_q),
  .irq       (wdt_irq),
  .rst       (wdt_rst)
);

// File: tb/test_wdt_apb_top.sv
`timescale 1ns/1ps
module test_wdt_apb_top;
  localparam logic [11:0] A_LOAD = 12'h000, A_CNT = 12'h004, A_CTRL = 12'h008,
                          A_ICLR = 12'h00C, A_RAW = 12'h010, A_MSK = 12'h014,
                          A_LOCK = 12'hC00, A_TCTL = 12'hF00, A_TSET = 12'hF04;
  localparam logic [31:0] KEY = 32'h1ACCE551;

  logic        clk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr, wdt_irq, wdt_rst;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  wdt_apb_top i_wdt_apb_top (
    .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .wdt_irq(wdt_irq), .wdt_rst(wdt_rst)
  );

  function automatic void chk(logic [31:0] act, logic [31:0] exp, string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endfunction

  // Monitor: pops the expected read value during each read access phase.
  always @(negedge clk) begin
    exp_t e;
    if (psel && penable && !pwrite) begin
      if (sb.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL scoreboard: actual read with no expectation, expected queued item");
      end else begin
        e = sb.pop_front();
        chk(prdata, e.exp, e.tag);
      end
    end
  end

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(posedge clk); #1;
    penable = 1'b1;
    @(posedge clk); #1;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  // Driver: queues the expectation, then performs the read.
  task automatic rd_exp(input logic [11:0] a, input logic [31:0] e, input string tag);
    exp_t it;
    it.exp = e; it.tag = tag;
    sb.push_back(it);
    @(posedge clk); #1;
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(posedge clk); #1;
    penable = 1'b1;
    @(posedge clk); #1;
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic do_reset();
    presetn = 1'b0;
    repeat (3) @(posedge clk);
    #1 presetn = 1'b1;
  endtask

  task automatic cycles_until(input bit want_rst, output int n);
    n = 0;
    while (((want_rst ? wdt_rst : wdt_irq) !== 1'b1) && n < 2000) begin
      @(posedge clk); #1;
      n++;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung run, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    do_reset();

    // R1 reset state
    chk({31'b0, wdt_irq}, 0, "R1 irq after reset");
    chk({31'b0, wdt_rst}, 0, "R1 rst after reset");
    rd_exp(A_LOCK, 1, "R1 lock after reset");
    rd_exp(A_LOAD, 32'hFFFFFFFF, "R1 load after reset");
    rd_exp(A_CNT, 32'hFFFFFFFF, "R1 count after reset");
    rd_exp(A_CTRL, 0, "R1 ctrl after reset");

    // R3 writes while locked
    bus_wr(A_LOAD, 32'h40);
    rd_exp(A_LOAD, 32'hFFFFFFFF, "R3 load write ignored");
    bus_wr(A_CTRL, 32'h3);
    rd_exp(A_CTRL, 0, "R3 ctrl write ignored");
    rd_exp(A_CNT, 32'hFFFFFFFF, "R3 counter still idle");

    // R2 key handling
    bus_wr(A_LOCK, KEY);
    rd_exp(A_LOCK, 0, "R2 unlocked by key");
    bus_wr(A_LOCK, 32'h2BDDF662);
    rd_exp(A_LOCK, 1, "R2 relocked");
    bus_wr(A_LOCK, KEY);
    bus_wr(A_LOCK, 32'h12345678);
    rd_exp(A_LOCK, 1, "R2 other value locks");
    bus_wr(A_LOCK, KEY);

    // R4 load write with counter stopped
    bus_wr(A_LOAD, 100);
    rd_exp(A_CNT, 100, "R4 count takes load");
    rd_exp(A_LOAD, 100, "R4 load readback");
    rd_exp(A_CNT, 100, "R5 count held while disabled");

    // R6 period L+1
    bus_wr(A_CTRL, 32'h1);
    cycles_until(1'b0, n);
    chk(n, 101, "R6 expiry period");
    rd_exp(A_CNT, 98, "R6 reload after expiry");
    rd_exp(A_CNT, 95, "R5 decrement step");
    rd_exp(A_CNT, 92, "R5 decrement step again");
    rd_exp(A_RAW, 1, "R9 raw set");
    rd_exp(A_MSK, 1, "R9 masked set");
    chk({31'b0, wdt_rst}, 0, "R7 no reset with bit1 clear");

    // R9 masking by control bit 0
    bus_wr(A_CTRL, 32'h0);
    rd_exp(A_MSK, 0, "R9 masked off");
    rd_exp(A_RAW, 1, "R9 raw held");
    chk({31'b0, wdt_irq}, 0, "R9 irq output masked");

    // R8 interrupt clear reloads
    bus_wr(A_CTRL, 32'h1);
    bus_wr(A_ICLR, 32'h1);
    rd_exp(A_CNT, 98, "R8 clear reloads count");
    rd_exp(A_RAW, 0, "R8 raw cleared");
    chk({31'b0, wdt_irq}, 0, "R8 irq output low");

    // R7 two-stage escalation
    bus_wr(A_CTRL, 32'h0);
    bus_wr(A_LOAD, 5);
    bus_wr(A_CTRL, 32'h3);
    cycles_until(1'b0, n);
    chk(n, 6, "R6 short period");
    cycles_until(1'b1, n);
    chk(n, 6, "R7 reset one period later");
    bus_wr(A_ICLR, 32'h1);
    chk({31'b0, wdt_rst}, 1, "R7 reset sticky");
    chk({31'b0, wdt_irq}, 0, "R8 irq cleared");

    // R7 no escalation with bit1 clear
    do_reset();
    bus_wr(A_LOCK, KEY);
    bus_wr(A_LOAD, 5);
    bus_wr(A_CTRL, 32'h1);
    repeat (30) @(posedge clk);
    #1;
    chk({31'b0, wdt_irq}, 1, "R7 irq pending");
    chk({31'b0, wdt_rst}, 0, "R7 reset disabled");

    // R10 test mode
    bus_wr(A_TCTL, 32'h1);
    bus_wr(A_TSET, 32'h2);
    chk({30'b0, wdt_rst, wdt_irq}, 32'h2, "R10 drive rst only");
    bus_wr(A_TSET, 32'h1);
    chk({30'b0, wdt_rst, wdt_irq}, 32'h1, "R10 drive irq only");
    rd_exp(A_TCTL, 1, "R10 test control readback");
    bus_wr(A_TCTL, 32'h0);
    chk({30'b0, wdt_rst, wdt_irq}, 32'h1, "R10 back to counter path");
    bus_wr(A_LOCK, 32'h0);
    bus_wr(A_TSET, 32'h2);
    bus_wr(A_TCTL, 32'h1);
    chk({30'b0, wdt_rst, wdt_irq}, 32'h1, "R3 test mode write ignored");
    rd_exp(A_TCTL, 0, "R3 test control unchanged");

    // R11 unmapped and write-only reads
    rd_exp(12'h100, 0, "R11 unmapped reads zero");
    rd_exp(A_TSET, 0, "R11 write-only reads zero");
    rd_exp(A_ICLR, 0, "R11 clear word reads zero");
    chk({30'b0, pready, pslverr}, 32'h2, "R11 pready high pslverr low");

    @(posedge clk); #1;
    chk(sb.size(), 0, "scoreboard drained");
    done = 1'b1;
    summary();
    $finish;
  end
endmodule